// File: doc/BRIEF.md
# Guarded Low-Power Mode Controller

This controller sits beside a small 8-bit processor core and decides when the core, its peripherals, its watchdog and its two oscillators receive a clock. Software drives it through a bit-set power-control register port: each write ORs data into the register. Entering either low-power state needs a pair of consecutive writes, so a single stray write can never stop the machine. The controller itself runs from an always-on clock that is separate from the oscillators it gates.

There are two low-power states. In the light one (idle), the processor clock and the watchdog clock are off, and the remaining peripherals keep running. Any enabled interrupt request ends idle. In the deep one (power down), both oscillators are switched off. Three things end power down: a low level on an asynchronous wake pin, a bus-activity strobe, or a hardware reset. A pin or bus wake keeps the frozen register contents. It turns the oscillators back on and holds the processor clock off for a programmable number of oscillator-ready cycles. A reset instead raises a register-reset request and restarts everything at once.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rstN` is low, and until the first rising clock edge after it is released, `regResetReq` is 1, `modeStatus` is 00 and all five enables are 1. From that edge on, `regResetReq` is 0.
- R2: Idle entry takes two writes. The first sets bit 0 and the second sets bit 5. After the clock edge that accepts the second write, `modeStatus` reads 01.
- R3: Power-down entry takes two writes. The first sets bit 1 and the second sets bit 6, and `modeStatus` then reads 10. If one write completes both pairs at once, power down wins.
- R4: The completing write must be the next accepted write after the arming write. Clock cycles with no write in between do not disarm. Any other write cancels the arming. A completing bit with no arming before it does nothing. A write that sets any bit outside {0,1,5,6} arms nothing and completes nothing.
- R5: In idle, `cpuClkEn` and `wdtClkEn` are 0, while `periphClkEn`, `rcOscEn` and `xtalOscEn` are 1.
- R6: Idle ends on the edge that samples `intReq` high, and the block returns to run. While idle, `busWake`, the wake pin and register writes have no effect.
- R7: In power down, all five enables are 0. `intReq` and register writes are ignored.
- R8: A `busWake` pulse ends power down on the edge that samples it. A low level on `wakePinN` ends power down on the third rising edge after that low level is set up, because it passes through a two-stage synchronizer. Both oscillator enables then go to 1, while `cpuClkEn`, `periphClkEn` and `wdtClkEn` stay 0 and `regResetReq` stays 0.
- R9: The settle phase counts cycles in which `oscReady` is high. It returns to run one cycle after `settleCount` such cycles have been counted. With `oscReady` held high, the settle phase lasts `settleCount`+1 cycles, and each cycle of low `oscReady` adds one more.
- R10: A hardware reset during power down brings all enables to 1 and returns the block to run at once, with `regResetReq` at 1.
- R11: `modeStatus` reads 00 in run, 01 in idle, and 10 both in power down and during the settle phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| regWrEn | input | 1 | Power-control register write strobe |
| regWrData | input | 8 | Bit-set write data |
| intReq | input | 1 | Enabled interrupt request (level) |
| wakePinN | input | 1 | Asynchronous active-low wake pin |
| busWake | input | 1 | One-cycle bus-activity wake strobe |
| oscReady | input | 1 | Oscillator-ready qualifier for the settle count |
| settleCount | input | 8 | Required number of oscillator-ready settle cycles |
| cpuClkEn | output | 1 | Processor clock enable |
| periphClkEn | output | 1 | Clock enable for the interrupt logic, serial port, USB logic and timers |
| wdtClkEn | output | 1 | Watchdog clock enable |
| rcOscEn | output | 1 | RC oscillator enable |
| xtalOscEn | output | 1 | Crystal oscillator enable |
| regResetReq | output | 1 | Register-reset request |
| modeStatus | output | 2 | Current mode: 00 run, 01 idle, 10 power down or settle |

## Verification
The settle-count bound assumes that `settleCount` does not change while a wake is settling. The bench sets it only while the block is running. The priority and consumed-arming properties assume that `busWake` is a single-cycle pulse and that writes arrive only as one-cycle strobes. Every scenario drives them that way, and changes inputs only on the falling edge. The wake pin is treated as fully asynchronous. The bench pulses it for one cycle to show that the synchronizer still catches a short low.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  localparam int PCR_W        = 8;
  localparam int BIT_IDLE_ARM = 0;
  localparam int BIT_PD_ARM   = 1;
  localparam int BIT_IDLE_GO  = 5;
  localparam int BIT_PD_GO    = 6;

  localparam logic [PCR_W-1:0] SEQ_MASK =
      (PCR_W'(1) << BIT_IDLE_ARM) | (PCR_W'(1) << BIT_PD_ARM) |
      (PCR_W'(1) << BIT_IDLE_GO)  | (PCR_W'(1) << BIT_PD_GO);

  typedef enum logic [1:0] {
    ST_RUN    = 2'b00,
    ST_IDLE   = 2'b01,
    ST_PDOWN  = 2'b10,
    ST_SETTLE = 2'b11
  } pwrState_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic acceptWr;
    logic settleClr;
    logic settleRun;
  } ctrlStrobe_t;

  // events from the datapath to the control FSM
  typedef struct packed {
    logic idleGo;
    logic pdGo;
    logic pdWake;
    logic settleDone;
  } dpEvent_t;

endpackage

// File: rtl/pwr_mode_dp.sv
module pwr_mode_dp
  import pwr_mode_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [PCR_W-1:0] regWrData,
  input  logic             wakePinN,
  input  logic             busWake,
  input  logic             oscReady,
  input  logic [CNT_W-1:0] settleCount,
  input  ctrlStrobe_t      strobe,
  output dpEvent_t         ev,
  output logic             regResetReq
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic                   armIdleQ, armPdQ;
  logic [SYNC_STAGES-1:0] pinSyncQ;
  logic [CNT_W-1:0]       cntQ;
  logic                   rstReqQ;
  logic                   acceptedWr, reservedHit, cleanWr, entering;

  // ---------------- write decode and arming ----------------
  assign acceptedWr  = regWrEn & strobe.acceptWr;
  assign reservedHit = |(regWrData & ~SEQ_MASK);
  assign cleanWr     = acceptedWr & ~reservedHit;

  assign ev.idleGo = cleanWr & armIdleQ & regWrData[BIT_IDLE_GO];
  assign ev.pdGo   = cleanWr & armPdQ   & regWrData[BIT_PD_GO];
  assign entering  = ev.idleGo | ev.pdGo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armIdleQ <= 1'b0;
      armPdQ   <= 1'b0;
    end else if (!strobe.acceptWr) begin
      armIdleQ <= 1'b0;
      armPdQ   <= 1'b0;
    end else if (regWrEn) begin
      armIdleQ <= cleanWr & ~entering & regWrData[BIT_IDLE_ARM];
      armPdQ   <= cleanWr & ~entering & regWrData[BIT_PD_ARM];
    end
  end

  // arming is consumed by the write that completes an entry
  assert_arm_consumed_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ev.idleGo || ev.pdGo) |=> (!armIdleQ && !armPdQ));

  // ---------------- wake pin synchronizer ----------------
  generate
    if (SYNC_STAGES > 1) begin : gSyncChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pinSyncQ <= '1;
        else       pinSyncQ <= {pinSyncQ[SYNC_STAGES-2:0], wakePinN};
      end
    end else begin : gSyncSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pinSyncQ <= '1;
        else       pinSyncQ <= wakePinN;
      end
    end
  endgenerate

  assign ev.pdWake = ~pinSyncQ[LAST_STAGE] | busWake;

  // ---------------- oscillator settle counter ----------------
  assign ev.settleDone = (cntQ == settleCount);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                         cntQ <= '0;
    else if (strobe.settleClr)                         cntQ <= '0;
    else if (strobe.settleRun && oscReady && !ev.settleDone) cntQ <= cntQ + 1'b1;
  end

  // counter never passes the programmed limit (settleCount held stable)
  assert_settle_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.settleRun |-> (cntQ <= settleCount));

  // ---------------- register-reset request ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstReqQ <= 1'b1;
    else       rstReqQ <= 1'b0;
  end

  assign regResetReq = rstReqQ;

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        intReq,
  input  dpEvent_t    ev,
  output ctrlStrobe_t strobe,
  output logic        cpuClkEn,
  output logic        periphClkEn,
  output logic        wdtClkEn,
  output logic        rcOscEn,
  output logic        xtalOscEn,
  output logic [1:0]  modeStatus
);

  pwrState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_RUN: begin
        if (ev.pdGo)        stateD = ST_PDOWN;
        else if (ev.idleGo) stateD = ST_IDLE;
      end
      ST_IDLE:   if (intReq)        stateD = ST_RUN;
      ST_PDOWN:  if (ev.pdWake)     stateD = ST_SETTLE;
      ST_SETTLE: if (ev.settleDone) stateD = ST_RUN;
      default:                      stateD = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_RUN;
    else       stateQ <= stateD;
  end

  assign strobe.acceptWr  = (stateQ == ST_RUN);
  assign strobe.settleRun = (stateQ == ST_SETTLE);
  assign strobe.settleClr = (stateQ != ST_SETTLE);

  always_comb begin
    cpuClkEn    = 1'b1;
    periphClkEn = 1'b1;
    wdtClkEn    = 1'b1;
    rcOscEn     = 1'b1;
    xtalOscEn   = 1'b1;
    modeStatus  = 2'b00;
    unique case (stateQ)
      ST_IDLE: begin
        cpuClkEn   = 1'b0;
        wdtClkEn   = 1'b0;
        modeStatus = 2'b01;
      end
      ST_PDOWN: begin
        cpuClkEn    = 1'b0;
        periphClkEn = 1'b0;
        wdtClkEn    = 1'b0;
        rcOscEn     = 1'b0;
        xtalOscEn   = 1'b0;
        modeStatus  = 2'b10;
      end
      ST_SETTLE: begin
        cpuClkEn    = 1'b0;
        periphClkEn = 1'b0;
        wdtClkEn    = 1'b0;
        modeStatus  = 2'b10;
      end
      default: ;
    endcase
  end

  assert_idle_exit_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && intReq) |=> (stateQ == ST_RUN));

  assert_pd_priority_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_RUN && ev.pdGo) |=> (stateQ == ST_PDOWN));

  assert_pd_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_PDOWN && !ev.pdWake) |=> (stateQ == ST_PDOWN));

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [PCR_W-1:0] regWrData,
  input  logic             intReq,
  input  logic             wakePinN,
  input  logic             busWake,
  input  logic             oscReady,
  input  logic [CNT_W-1:0] settleCount,
  output logic             cpuClkEn,
  output logic             periphClkEn,
  output logic             wdtClkEn,
  output logic             rcOscEn,
  output logic             xtalOscEn,
  output logic             regResetReq,
  output logic [1:0]       modeStatus
);

  ctrlStrobe_t strobe;
  dpEvent_t    ev;

  pwr_mode_dp #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .wakePinN(wakePinN), .busWake(busWake), .oscReady(oscReady),
    .settleCount(settleCount), .strobe(strobe), .ev(ev),
    .regResetReq(regResetReq)
  );

  pwr_mode_fsm fsm_i (
    .clk(clk), .rstN(rstN), .intReq(intReq), .ev(ev), .strobe(strobe),
    .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn), .wdtClkEn(wdtClkEn),
    .rcOscEn(rcOscEn), .xtalOscEn(xtalOscEn), .modeStatus(modeStatus)
  );

  // processor never clocked without both oscillators
  assert_cpu_needs_osc_R8: assert property (@(posedge clk) disable iff (!rstN)
    cpuClkEn |-> (rcOscEn && xtalOscEn));

  // idle keeps peripherals but stops watchdog and processor
  assert_idle_gating_R5: assert property (@(posedge clk) disable iff (!rstN)
    (modeStatus == 2'b01) |-> (!cpuClkEn && !wdtClkEn && periphClkEn));

  // once dropped, the register-reset request stays low until the next reset
  assert_rstreq_once_R1: assert property (@(posedge clk) disable iff (!rstN)
    !regResetReq |=> !regResetReq);

endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       regWrEn;
  logic [7:0] regWrData;
  logic       intReq, wakePinN, busWake, oscReady;
  logic [7:0] settleCount;
  logic       cpuClkEn, periphClkEn, wdtClkEn, rcOscEn, xtalOscEn, regResetReq;
  logic [1:0] modeStatus;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pwr_mode_ctrl dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .intReq(intReq), .wakePinN(wakePinN), .busWake(busWake),
    .oscReady(oscReady), .settleCount(settleCount),
    .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn), .wdtClkEn(wdtClkEn),
    .rcOscEn(rcOscEn), .xtalOscEn(xtalOscEn), .regResetReq(regResetReq),
    .modeStatus(modeStatus)
  );

  // enables packed as {cpu, periph, wdt, rc, xtal}
  function automatic logic [4:0] ens();
    return {cpuClkEn, periphClkEn, wdtClkEn, rcOscEn, xtalOscEn};
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(logic [7:0] d);
    regWrEn = 1'b1; regWrData = d;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0; regWrData = 8'h00;
  endtask

  task automatic apply_reset();
    rstN = 1'b0; regWrEn = 1'b0; regWrData = 8'h00; intReq = 1'b0;
    wakePinN = 1'b1; busWake = 1'b0; oscReady = 1'b1; settleCount = 8'd4;
    cyc(2);
    rstN = 1'b1;
    cyc(1);
  endtask

  task automatic bus_wake_and_settle();
    busWake = 1'b1;
    @(posedge clk); @(negedge clk);
    busWake = 1'b0;
    while (!cpuClkEn) cyc(1);
  endtask

  task automatic t_reset();
    rstN = 1'b0; regWrEn = 1'b0; regWrData = 8'h00; intReq = 1'b0;
    wakePinN = 1'b1; busWake = 1'b0; oscReady = 1'b1; settleCount = 8'd4;
    cyc(2);
    check("R1", "reqResetReq in reset", regResetReq, 1);
    check("R1", "enables in reset", ens(), 5'b11111);
    check("R11", "mode in reset", modeStatus, 0);
    rstN = 1'b1;
    #1;
    check("R1", "reqResetReq before first edge", regResetReq, 1);
    @(posedge clk); @(negedge clk);
    check("R1", "reqResetReq after first edge", regResetReq, 0);
  endtask

  task automatic t_idle();
    wr(8'h01); cyc(3); wr(8'h20);
    check("R2", "mode after idle pair with gap", modeStatus, 1);
    check("R11", "idle code", modeStatus, 2'b01);
    check("R5", "idle enables", ens(), 5'b01011);
    busWake = 1'b1; wakePinN = 1'b0; cyc(1); busWake = 1'b0; cyc(3); wakePinN = 1'b1;
    check("R6", "idle ignores wake sources", modeStatus, 1);
    wr(8'h02); wr(8'h40);
    check("R6", "idle ignores writes", modeStatus, 1);
    intReq = 1'b1; cyc(1); intReq = 1'b0;
    check("R6", "run after interrupt", modeStatus, 0);
    check("R6", "enables after interrupt", ens(), 5'b11111);
    cyc(2);
  endtask

  task automatic t_arm_rules();
    wr(8'h20);
    check("R4", "unarmed completion bit", modeStatus, 0);
    wr(8'h01); wr(8'h10); wr(8'h20);
    check("R4", "intervening write cancels", modeStatus, 0);
    wr(8'h01); wr(8'h40); wr(8'h20);
    check("R4", "wrong completion cancels", modeStatus, 0);
    wr(8'h01); wr(8'hA0);
    check("R4", "reserved bit blocks completion", modeStatus, 0);
    wr(8'h81); wr(8'h20);
    check("R4", "reserved bit blocks arming", modeStatus, 0);
    wakePinN = 1'b0; cyc(4); wakePinN = 1'b1; cyc(3);
    check("R8", "wake pin ignored in run", modeStatus, 0);
  endtask

  task automatic t_pd_bus();
    int n;
    settleCount = 8'd4; oscReady = 1'b1;
    wr(8'h02); wr(8'h40);
    check("R3", "power down mode", modeStatus, 2);
    check("R7", "power down enables", ens(), 5'b00000);
    intReq = 1'b1; cyc(2); intReq = 1'b0;
    wr(8'h01); wr(8'h20);
    check("R7", "interrupt and writes ignored", modeStatus, 2);
    check("R7", "enables still off", ens(), 5'b00000);
    busWake = 1'b1;
    @(posedge clk); @(negedge clk);
    busWake = 1'b0;
    check("R8", "settle enables after bus wake", ens(), 5'b00011);
    check("R8", "no reset request on bus wake", regResetReq, 0);
    check("R11", "settle code", modeStatus, 2);
    n = 0;
    while (!cpuClkEn && n < 100) begin n++; cyc(1); end
    check("R9", "settle length oscReady high", n, 5);
    check("R9", "run after settle", modeStatus, 0);
    check("R9", "all enables after settle", ens(), 5'b11111);
  endtask

  task automatic t_pd_pin();
    int n;
    settleCount = 8'd3; oscReady = 1'b0;
    wr(8'h02); wr(8'h40);
    wakePinN = 1'b0;
    @(posedge clk); @(negedge clk);
    wakePinN = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8", "still asleep during sync", ens(), 5'b00000);
    @(posedge clk); @(negedge clk);
    check("R8", "settle enables after pin wake", ens(), 5'b00011);
    check("R8", "no reset request on pin wake", regResetReq, 0);
    n = 0;
    while (!cpuClkEn && n < 100) begin
      n++;
      if (n == 3) oscReady = 1'b1;
      cyc(1);
    end
    check("R9", "settle length with stalled oscReady", n, 6);
    oscReady = 1'b1;
  endtask

  task automatic t_zero_settle();
    int n;
    settleCount = 8'd0;
    wr(8'h02); wr(8'h40);
    busWake = 1'b1;
    @(posedge clk); @(negedge clk);
    busWake = 1'b0;
    n = 0;
    while (!cpuClkEn && n < 100) begin n++; cyc(1); end
    check("R9", "zero settle count length", n, 1);
    settleCount = 8'd4;
  endtask

  task automatic t_priority();
    wr(8'h03); wr(8'h60);
    check("R3", "power down wins over idle", modeStatus, 2);
    bus_wake_and_settle();
    check("R3", "back to run", modeStatus, 0);
  endtask

  task automatic t_reset_in_pd();
    wr(8'h02); wr(8'h40);
    check("R10", "in power down before reset", modeStatus, 2);
    rstN = 1'b0;
    #2;
    check("R10", "enables on reset", ens(), 5'b11111);
    check("R10", "reset request on reset", regResetReq, 1);
    check("R10", "mode on reset", modeStatus, 0);
    @(negedge clk);
    rstN = 1'b1;
    cyc(1);
    check("R10", "request drops after reset", regResetReq, 0);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_arm_rules();
    t_pd_bus();
    t_pd_pin();
    t_zero_settle();
    t_priority();
    t_reset_in_pd();
    apply_reset();
    check("R1", "final run state", ens(), 5'b11111);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

endmodule